// File: doc/BRIEF.md
# Saturating Trigger Interval Meter

This block times the gap between trigger events on one serial channel. A counter advances by one on every cycle in which the prescaled-rate tick input is high. When either of the two trigger inputs fires, the counter's current value is stored in a captured-value register and the counter restarts from zero. In the same step a one-cycle capture-valid strobe and a one-cycle transmit-shift event pulse are raised. The counter does not wrap. It stops at its all-ones value, so a gap that is too long reads as the maximum.

The enable input gates the whole function. While it is low, triggers are ignored, the counter is held at zero and the last captured value is kept. A small controller tracks three states. `ST_OFF` means measurement is disabled. `ST_RUN` means counting below the maximum. `ST_FULL` means saturated.

The controller's transitions are:
- `ST_OFF -> ST_RUN`: enable rises.
- `ST_RUN -> ST_FULL`: a tick arrives at one below the maximum with no trigger.
- `ST_FULL -> ST_RUN` and `ST_RUN -> ST_RUN`: any trigger.
- `ST_RUN`/`ST_FULL -> ST_OFF`: enable falls.

All outputs are registered. A trigger sampled at one clock edge is visible on the outputs just after that edge.

Top module: `tim_trig_meter`

## Requirements
- R1: While `meas_en` is 0, triggers on `trig_a`/`trig_b` cause no strobe or shift pulse and leave `cap_value` unchanged.
- R2: While `meas_en` is 1 and no trigger is present, the counter grows by exactly 1 for each cycle with `rate_tick` high and holds otherwise.
- R3: The counter stops at 2^CNT_W-1 (1023 by default) and never wraps; a capture after any longer gap reads 1023.
- R4: With `meas_en` 1, a trigger on either input loads the current count into `cap_value`, visible after the same clock edge.
- R5: The trigger clears the counter, so the next capture measures ticks counted from that trigger.
- R6: Each trigger cycle raises `cap_valid` and `shift_evt` together for exactly one clock; both are 0 in a following cycle with no trigger.
- R7: A tick and a trigger in the same cycle capture the value before that tick, and the counter ends at 0.
- R8: Triggers on both inputs in the same cycle form one event: one capture, one pulse.
- R9: Lowering `meas_en` returns the counter to 0 and keeps the last `cap_value`.
- R10: After reset `cap_value` is 0, `cap_valid` and `shift_evt` are 0, and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_en | input | 1 | Measurement enable |
| rate_tick | input | 1 | Prescaled-rate count tick, one clock wide |
| trig_a | input | 1 | First trigger pulse |
| trig_b | input | 1 | Second trigger pulse |
| cap_value | output | CNT_W (10) | Last captured count |
| cap_valid | output | 1 | One-cycle strobe: `cap_value` just updated |
| shift_evt | output | 1 | One-cycle transmit-shift event |

## Verification
Two functions can fall in the same cycle: counting a tick and capturing on a trigger. The bench drives `rate_tick` and a trigger together, both while counting normally and while the counter is saturated. It judges the result through the captured value, which must be the count before that tick, and through the next capture, which must count only ticks after the clear. A second collision is a trigger on both inputs at once, and it is judged by a single capture and pulse.

// File: rtl/tim_meter_pkg.sv
package tim_meter_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } meas_state_e;

endpackage

// File: rtl/tim_trig_merge.sv
module tim_trig_merge #(
    parameter int N_TRIG = 2
) (
    input  logic              en,
    input  logic [N_TRIG-1:0] trig,
    output logic              fire
);

    logic [N_TRIG:0] any_chain;

    assign any_chain[0] = 1'b0;

    generate
        for (genvar g = 0; g < N_TRIG; g++) begin : g_or
            assign any_chain[g+1] = any_chain[g] | trig[g];
        end
    endgenerate

    // Triggers are ignored unless measurement is enabled
    assign fire = en & any_chain[N_TRIG];

endmodule

// File: rtl/tim_sat_counter.sv
module tim_sat_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             near_max,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    assign near_max = (count == CNT_LAST);
    assign at_max   = (count == CNT_MAX);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> at_max); // R3

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !at_max) |=> (count == $past(count) + 1'b1)); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count)); // R2

endmodule

// File: rtl/tim_capture.sv
module tim_capture #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_value <= '0;
            cap_valid <= 1'b0;
        end else begin
            cap_valid <= fire;
            if (fire) begin
                cap_value <= count;
            end
        end
    end

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (cap_value == $past(count))); // R4

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(cap_value)); // R1

endmodule

// File: rtl/tim_ctrl_fsm.sv
module tim_ctrl_fsm
    import tim_meter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        tick,
    input  logic        fire,
    input  logic        near_max,
    output logic        cnt_clr,
    output logic        cnt_inc,
    output logic        shift_evt,
    output meas_state_e state_o
);

    meas_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin
                    if (!fire && tick && near_max) state_d = ST_FULL;
                    else                           state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en)                       state_d = ST_OFF;
                else if (fire)                 state_d = ST_RUN;
                else if (tick && near_max)     state_d = ST_FULL;
            end
            ST_FULL: begin
                if (!en)       state_d = ST_OFF;
                else if (fire) state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Counter controls: a trigger wins over a tick in the same cycle
    assign cnt_clr = !en || fire;
    assign cnt_inc = en && tick && !fire && (state_q != ST_FULL);

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_evt <= 1'b0;
        end else begin
            shift_evt <= fire;
        end
    end

    assign state_o = state_q;

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_OFF)); // R9

    AST_FIRE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == ST_RUN)); // R5

endmodule

// File: rtl/tim_trig_meter.sv
module tim_trig_meter
    import tim_meter_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_en,
    input  logic             rate_tick,
    input  logic             trig_a,
    input  logic             trig_b,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_valid,
    output logic             shift_evt
);

    localparam int N_TRIG = 2;

    logic             fire;
    logic             cnt_clr;
    logic             cnt_inc;
    logic             near_max;
    logic             at_max;
    logic [CNT_W-1:0] count;
    meas_state_e      state;

    tim_trig_merge #(.N_TRIG(N_TRIG)) i_merge (
        .en   (meas_en),
        .trig ({trig_b, trig_a}),
        .fire (fire)
    );

    tim_ctrl_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (meas_en),
        .tick      (rate_tick),
        .fire      (fire),
        .near_max  (near_max),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .shift_evt (shift_evt),
        .state_o   (state)
    );

    tim_sat_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .count    (count),
        .near_max (near_max),
        .at_max   (at_max)
    );

    tim_capture #(.CNT_W(CNT_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .count     (count),
        .cap_value (cap_value),
        .cap_valid (cap_valid)
    );

    AST_PULSE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid == shift_evt); // R6

    AST_FULL_TRACKS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) == at_max); // R3

    AST_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (count == '0)); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> ((count == '0) && !cap_valid && !shift_evt)); // R9

    AST_TICK_LOST_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rate_tick) |=> (cap_value == $past(count))); // R7

endmodule

// File: tb/test_tim_trig_meter.sv
module test_tim_trig_meter;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int N_ROWS     = 20;

    // Row layout: [26] en, [25] tick, [24] trig_a, [23] trig_b,
    // [22:11] repeat count, [10] expected valid, [9:0] expected capture
    localparam logic [26:0] VEC [N_ROWS] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd5,    1'b0, 10'd0},
        {1'b1, 1'b0, 1'b1, 1'b0, 12'd1,    1'b1, 10'd5},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd3,    1'b0, 10'd5},
        {1'b1, 1'b0, 1'b0, 1'b0, 12'd4,    1'b0, 10'd5},
        {1'b1, 1'b0, 1'b0, 1'b1, 12'd1,    1'b1, 10'd3},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd7,    1'b0, 10'd3},
        {1'b1, 1'b1, 1'b1, 1'b0, 12'd1,    1'b1, 10'd7},
        {1'b1, 1'b0, 1'b1, 1'b1, 12'd1,    1'b1, 10'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd2,    1'b0, 10'd0},
        {1'b1, 1'b0, 1'b1, 1'b0, 12'd1,    1'b1, 10'd2},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd6,    1'b0, 10'd2},
        {1'b0, 1'b1, 1'b1, 1'b1, 12'd3,    1'b0, 10'd2},
        {1'b1, 1'b0, 1'b0, 1'b1, 12'd1,    1'b1, 10'd0},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd1022, 1'b0, 10'd0},
        {1'b1, 1'b0, 1'b1, 1'b0, 12'd1,    1'b1, 10'd1022},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd1023, 1'b0, 10'd1022},
        {1'b1, 1'b0, 1'b1, 1'b0, 12'd1,    1'b1, 10'd1023},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'd1500, 1'b0, 10'd1023},
        {1'b1, 1'b0, 1'b0, 1'b1, 12'd1,    1'b1, 10'd1023},
        {1'b1, 1'b1, 1'b0, 1'b1, 12'd1,    1'b1, 10'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             meas_en = 1'b0;
    logic             rate_tick = 1'b0;
    logic             trig_a = 1'b0;
    logic             trig_b = 1'b0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_valid;
    logic             shift_evt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tim_trig_meter #(.CNT_W(CNT_W)) i_tim_trig_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_en   (meas_en),
        .rate_tick (rate_tick),
        .trig_a    (trig_a),
        .trig_b    (trig_b),
        .cap_value (cap_value),
        .cap_valid (cap_valid),
        .shift_evt (shift_evt)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic e, input logic t, input logic a, input logic b);
        @(negedge clk);
        meas_en   = e;
        rate_tick = t;
        trig_a    = a;
        trig_b    = b;
        @(posedge clk);
        #1;
    endtask

    function automatic string row_tag(input int i);
        case (i)
            1, 4:        return "R4";
            3, 5:        return "R2";
            6, 19:       return "R7";
            7:           return "R8";
            9:           return "R5";
            11:          return "R1";
            12:          return "R9";
            16, 17, 18:  return "R3";
            default:     return "R2";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10", "cap_value", int'(cap_value), 0);
        check("R10", "cap_valid", int'(cap_valid), 0);
        check("R10", "shift_evt", int'(shift_evt), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < N_ROWS; i++) begin
            logic [26:0] v;
            v = VEC[i];
            for (int r = 0; r < int'(v[22:11]); r++) begin
                drive(v[26], v[25], v[24], v[23]);
            end
            check(row_tag(i), "cap_value", int'(cap_value), int'(v[9:0]));
            check(row_tag(i), "cap_valid", int'(cap_valid), int'(v[10]));
            check(row_tag(i), "shift_evt", int'(shift_evt), int'(v[10]));
        end

        // R6: pulses last one cycle
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R6", "cap_valid on trigger", int'(cap_valid), 1);
        check("R6", "cap_value on trigger", int'(cap_value), 1);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        check("R6", "cap_valid after", int'(cap_valid), 0);
        check("R6", "shift_evt after", int'(shift_evt), 0);

        // R7: tick + trigger while saturated, then next capture counts from zero
        for (int r = 0; r < 1100; r++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R7", "saturated capture", int'(cap_value), 1023);
        for (int r = 0; r < 4; r++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R7", "count after collision", int'(cap_value), 4);

        // R9: disable mid-count holds capture, counter restarts at zero
        for (int r = 0; r < 9; r++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        check("R9", "held capture", int'(cap_value), 4);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R9", "count restarted", int'(cap_value), 1);

        // R10: reset during operation
        for (int r = 0; r < 5; r++) drive(1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        meas_en = 1'b0;
        rate_tick = 1'b0;
        @(posedge clk);
        #1;
        check("R10", "cap_value after reset", int'(cap_value), 0);
        check("R10", "cap_valid after reset", int'(cap_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        check("R10", "counter after reset", int'(cap_value), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule